// File: doc/BRIEF.md
# Self-Timed Memory Write Sequencer

This block handles a write to a memory whose write time is not fixed. It takes one request carrying an address and a data word. It drives the row write for one cycle. After that it reads the same row back on every cycle and compares the result with the data it wrote. When a read-back matches, it waits a fixed number of guard cycles and then raises a one-cycle completion pulse. The guard cycles cover the half of the bitcell that a single-ended read cannot see.

The requester is stalled from the cycle after its request is taken until the completion cycle. A request that arrives during that time is held back, not dropped: the requester keeps it asserted, and it is taken in the completion cycle. If no read-back matches within a bounded number of verify cycles, the block sets an error flag and returns to idle without signalling completion.

Top module: `swc_wr_ctrl`

## Requirements
- R1: After reset, stall_o, done_o, err_o, mem_we_o and mem_re_o are all low.
- R2: A request is taken on a rising clock edge where req_i=1 and stall_o=0. In the next cycle, mem_we_o is high for exactly one cycle, with mem_addr_o and mem_wdata_o equal to the address and data that were taken.
- R3: In every cycle after the write cycle, up to the first matching read-back, mem_re_o is high, mem_we_o is low, and mem_addr_o holds the address that was taken.
- R4: When the read-back equals the written data, done_o goes high exactly REP_CYC+1 cycles after that matching read cycle. With write latency L (the number of cycles before the new row content becomes readable, at least 1), done_o is therefore seen in cycle L+1+REP_CYC, counting the write cycle as cycle 0.
- R5: done_o is a single-cycle pulse. stall_o is high in every cycle from the write cycle up to the cycle before done_o, and it is low in the done_o cycle.
- R6: If TMO_CYC verify cycles in a row all fail to match, the block returns to idle one cycle after the last of them. err_o rises and stall_o falls in that cycle (cycle TMO_CYC+1), and no done_o pulse is produced.
- R7: err_o stays high until the next request is taken. It is cleared by the edge that takes that request.
- R8: While stall_o is high, req_i has no effect: no new write is driven. A request held high through the stall is taken in the done_o cycle, and its write follows in the next cycle.
- R9: When the row already holds the write data, the first read-back matches, and done_o comes in cycle 1+1+REP_CYC whatever the write latency is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, held until taken |
| addr_i | input | AW | Write address |
| wdata_i | input | DW | Write data |
| stall_o | output | 1 | Requester must wait |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Verify timeout flag, cleared by the next request |
| mem_we_o | output | 1 | Row write enable |
| mem_re_o | output | 1 | Row read enable for read-back |
| mem_addr_o | output | AW | Row address |
| mem_wdata_o | output | DW | Row write data |
| mem_rdata_i | input | DW | Row read data, valid in the cycle of the read |

## Verification
Every result is timed from the edge that takes the request. The write strobe is due in cycle 0, the first read-back in cycle 1, done_o in cycle L+1+REP_CYC, and the error flag in cycle TMO_CYC+1. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the taking edge, and in each counted cycle it checks exactly the level that cycle should have, including every stalled cycle before completion and the cycle after the pulse. The memory model in the bench commits the new row content L-1 edges after the write edge, so the expected cycle numbers follow from L alone.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WRITE   = 3'd1,
    ST_VERIFY  = 3'd2,
    ST_REPLICA = 3'd3,
    ST_DONE    = 3'd4
  } swc_state_e;
endpackage

// File: rtl/swc_verify.sv
module swc_verify #(
  parameter int DW  = 8,
  parameter int TMO = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] expect_i,
  output logic          match_o,
  output logic          expire_o
);
  localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt_q;

  assign match_o  = active_i && (rdata_i == expect_i);
  assign expire_o = active_i && !match_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!active_i)       cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  // timeout must take the sequencer out of verify
  p_expire_exits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !active_i);
  // a match ends verify as well
  p_match_exits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !active_i);
endmodule

// File: rtl/swc_delay.sv
module swc_delay #(
  parameter int DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic expire_o
);
  generate
    if (DLY <= 1) begin : g_single
      assign expire_o = active_i;
    end else begin : g_count
      localparam int CW = $clog2(DLY);
      localparam logic [CW-1:0] LAST = CW'(DLY - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (!active_i)  cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
      assign expire_o = active_i && (cnt_q == LAST);
    end
  endgenerate

  p_guard_exits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !active_i);
endmodule

// File: rtl/swc_wr_ctrl.sv
module swc_wr_ctrl
  import swc_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int REP_CYC = 1,
  parameter int TMO_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          stall_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam bit HAS_GUARD = (REP_CYC > 0);

  swc_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          err_q;
  logic          accept;
  logic          in_verify, in_guard;
  logic          match, tmo, guard_end;

  assign in_verify = (state_q == ST_VERIFY);
  assign in_guard  = (state_q == ST_REPLICA);
  assign accept    = req_i && !stall_o;

  swc_verify #(.DW(DW), .TMO(TMO_CYC)) u_verify (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (in_verify),
    .rdata_i  (mem_rdata_i),
    .expect_i (wdata_q),
    .match_o  (match),
    .expire_o (tmo)
  );

  swc_delay #(.DLY(REP_CYC)) u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (in_guard),
    .expire_o (guard_end)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_WRITE;
      ST_WRITE:   state_d = ST_VERIFY;
      ST_VERIFY: begin
        if (match)    state_d = HAS_GUARD ? ST_REPLICA : ST_DONE;
        else if (tmo) state_d = ST_IDLE;
      end
      ST_REPLICA: if (guard_end) state_d = ST_DONE;
      ST_DONE:    state_d = accept ? ST_WRITE : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        err_q   <= 1'b0;
      end else if (tmo) begin
        err_q   <= 1'b1;
      end
    end
  end

  assign stall_o     = (state_q == ST_WRITE) || in_verify || in_guard;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_re_o    = in_verify;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  p_we_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> mem_we_o);
  p_we_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_we_re_apart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  p_read_addr_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (mem_addr_o == $past(mem_addr_o)));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_unstalled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !stall_o);
  p_err_no_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!done_o && !stall_o));
  p_err_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && accept) |=> !err_o);
  p_we_needs_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(req_i && !stall_o));
endmodule

// File: tb/tb_swc_wr_ctrl.sv
module tb_swc_wr_ctrl;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int REP = 1;
  localparam int TMO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          stall, done, err, we, re;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwdata, mrdata;

  int total = 0;
  int bad   = 0;
  int lat   = 1;

  always #2.5 clk = ~clk;

  swc_wr_ctrl #(.AW(AW), .DW(DW), .REP_CYC(REP), .TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .stall_o(stall), .done_o(done), .err_o(err), .mem_we_o(we), .mem_re_o(re),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  // slow memory: new content readable L-1 edges after the write edge
  logic [DW-1:0] mem [2**AW];
  logic          pend = 1'b0;
  int            pcnt = 0;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pdata;

  initial for (int i = 0; i < 2**AW; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (we) begin
      if (lat <= 1) mem[maddr] <= mwdata;
      else begin
        pend  <= 1'b1;
        pcnt  <= lat - 1;
        paddr <= maddr;
        pdata <= mwdata;
      end
    end else if (pend) begin
      if (pcnt == 1) begin
        mem[paddr] <= pdata;
        pend <= 1'b0;
      end
      pcnt <= pcnt - 1;
    end
  end

  assign mrdata = re ? mem[maddr] : '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // issue a request at a falling edge; returns once it is taken (cycle 0 sample point)
  task automatic issue(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  // full write with completion expected in cycle kexp
  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int l, input int kexp, input string rq);
    lat = l;
    @(negedge clk);
    issue(a, d);
    chk(we == 1'b1, "R2", "we in cycle 0", we, 1);
    chk(maddr == a && mwdata == d, "R2", "write addr/data", {maddr, mwdata}, {a, d});
    for (int k = 1; k < kexp; k++) begin
      @(negedge clk);
      chk(stall && !done, "R5", "stalled before done", {stall, done}, 2);
      chk(!we, "R3", "no write during verify", we, 0);
      if (k == 1) chk(re && maddr == a, "R3", "read-back of taken row", {re, maddr}, {1'b1, a});
    end
    @(negedge clk);
    chk(done == 1'b1, rq, "done at expected cycle", done, 1);
    chk(stall == 1'b0, "R5", "stall low with done", stall, 0);
    @(negedge clk);
    chk(done == 1'b0, "R5", "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(!stall && !done && !err && !we && !re, "R1", "outputs after reset",
        {stall, done, err, we, re}, 0);
  endtask

  task automatic t_timeout;
    lat = 40;
    @(negedge clk);
    issue(4'h5, 8'hA5);
    for (int k = 1; k <= TMO; k++) begin
      @(negedge clk);
      chk(stall && !done && !err, "R6", "still verifying", {stall, done, err}, 4);
    end
    @(negedge clk);
    chk(err && !stall && !done, "R6", "timeout flagged", {err, stall, done}, 4);
    repeat (45) begin
      @(negedge clk);
      if (done) chk(1'b0, "R6", "no done after timeout", done, 0);
    end
    chk(err == 1'b1, "R7", "err held while idle", err, 1);
    lat = 1;
    issue(4'h6, 8'h11);
    chk(err == 1'b0, "R7", "err cleared on take", err, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_held;
    int kd;
    lat = 3;
    @(negedge clk);
    issue(4'h9, 8'h3C);
    req = 1'b1; addr = 4'hA; wdata = 8'hC3;
    kd = 0;
    for (int k = 1; k <= 3 + REP + 2 && kd == 0; k++) begin
      @(negedge clk);
      if (done) kd = k;
      else chk(!we, "R8", "held request not written while stalled", we, 0);
    end
    chk(kd == 3 + 1 + REP, "R8", "first write completes", kd, 3 + 1 + REP);
    @(negedge clk);
    req = 1'b0;
    chk(we && maddr == 4'hA && mwdata == 8'hC3, "R8", "held request taken in done cycle",
        {we, maddr, mwdata}, {1'b1, 4'hA, 8'hC3});
    for (int k = 1; k < 3 + 1 + REP; k++) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R8", "held write completes", done, 1);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(4'h1, 8'h5A, 1, 1 + 1 + REP, "R4");
    t_write(4'h2, 8'hF0, 2, 2 + 1 + REP, "R4");
    t_write(4'h3, 8'h81, 3, 3 + 1 + REP, "R4");
    t_write(4'h3, 8'h81, 3, 1 + 1 + REP, "R9");
    t_write(4'hF, 8'hFF, 2, 2 + 1 + REP, "R4");
    t_timeout();
    t_held();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule